// File: doc/BRIEF.md
# Programmable Digital Audio Gain Stage

The block scales a stream of 16-bit signed linear PCM samples, typically arriving at 8 kHz, by a programmable fixed-point coefficient. The coefficient has its unity point at 0x4000 (14 fractional bits). The scale runs linearly from silence at 0x0000 to just under twice the amplitude at 0x7FFF. A separate mute bit forces the output to zero whatever the coefficient holds. Two identical lanes sit side by side, one for the transmit direction and one for the receive direction. Each lane has its own stream ports, coefficient and mute bit.

Each lane multiplies at full precision, rounds to the nearest output step and saturates instead of wrapping. The result is held in a single output register.

Both sample interfaces use valid/ready handshakes:
- A sample is accepted on a clock edge where its valid and ready are both high.
- A lane's input ready is high whenever its output register is empty or is being drained in the same cycle.
- While the downstream side holds ready low, the output sample stays on the pins unchanged.
- The coefficient and mute bit are plain control inputs. They are captured only when a sample is accepted.

Top module: `audio_gain_pair`

## Requirements
- R1: With a coefficient of 0x0000 the accepted sample produces an output of 0x0000.
- R2: With a coefficient of 0x4000 and mute low, the output equals the accepted input sample bit for bit, across the full signed range.
- R3: The coefficient is read as an unsigned 16-bit number. The output is floor((sample × coefficient + 0x2000) / 2^14), computed without loss, so halves round upward; for example, 1000 at 0x7FFF gives 2000.
- R4: A result above +32767 is delivered as 0x7FFF and one below −32768 as 0x8000, never wrapped.
- R5: When mute is high at acceptance, the output is 0x0000 regardless of the coefficient.
- R6: The transmit and receive lanes are independent: each uses only its own coefficient, mute bit and handshake.
- R7: After reset both outputs are not valid and both input readies are high. An accepted sample appears on the output with valid high on the very next clock edge.
- R8: While out_valid is high and out_ready is low, out_valid and out_data hold steady and in_ready is low. In all other cycles in_ready is high.
- R9: Coefficient and mute are sampled only on the edge that accepts a sample; changing them later does not alter a sample already accepted or being held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_in_valid | input | 1 | Transmit lane input sample valid |
| tx_in_ready | output | 1 | Transmit lane can accept a sample |
| tx_in_data | input | 16 | Transmit lane input sample, signed |
| tx_out_valid | output | 1 | Transmit lane output sample valid |
| tx_out_ready | input | 1 | Downstream accepts the transmit output |
| tx_out_data | output | 16 | Transmit lane scaled sample, signed |
| tx_gain | input | 16 | Transmit coefficient, 0x4000 is unity |
| tx_mute | input | 1 | Transmit digital mute |
| rx_in_valid | input | 1 | Receive lane input sample valid |
| rx_in_ready | output | 1 | Receive lane can accept a sample |
| rx_in_data | input | 16 | Receive lane input sample, signed |
| rx_out_valid | output | 1 | Receive lane output sample valid |
| rx_out_ready | input | 1 | Downstream accepts the receive output |
| rx_out_data | output | 16 | Receive lane scaled sample, signed |
| rx_gain | input | 16 | Receive coefficient, 0x4000 is unity |
| rx_mute | input | 1 | Receive digital mute |

## Verification
The scaled sample is due one clock edge after the edge that accepts its input. It then stays on the pins until the edge on which out_ready is high.

The bench drives inputs half a period before an edge. It decides from the settled handshakes which transfers that edge will make:
- An accepted input pushes a model value into a per-lane queue.
- A draining output is compared against the queue head.

Directed cases sample at the falling edge right after acceptance to pin down the single-cycle latency. They also hold ready low over several cycles to confirm that the held value and the captured coefficient do not change.

// File: rtl/gain_pkg.sv
package gain_pkg;
  localparam int SAMPLE_W  = 16;
  localparam int COEF_W    = 16;
  localparam int FRAC_BITS = 14;
  localparam int LANES     = 2;

  typedef enum logic [0:0] {
    LANE_TX = 1'b0,
    LANE_RX = 1'b1
  } lane_id_e;
endpackage

// File: rtl/gain_product.sv
module gain_product #(
  parameter int SW = gain_pkg::SAMPLE_W,
  parameter int CW = gain_pkg::COEF_W,
  parameter int FB = gain_pkg::FRAC_BITS,
  localparam int PW = SW + CW + 1,
  localparam int RW = PW - FB
) (
  input  logic signed [SW-1:0] sample,
  input  logic        [CW-1:0] coef,
  output logic signed [RW-1:0] scaled
);
  logic signed [PW-1:0] sample_x;
  logic signed [PW-1:0] coef_x;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] biased;
  logic signed [PW-1:0] shifted;

  // full precision: signed sample times unsigned coefficient
  always_comb begin
    sample_x = {{(PW-SW){sample[SW-1]}}, sample};
    coef_x   = {{(PW-CW){1'b0}}, coef};
    prod     = sample_x * coef_x;
    biased   = prod + (PW'(1) <<< (FB-1));
    shifted  = biased >>> FB;
  end

  assign scaled = RW'(shifted);
endmodule

// File: rtl/gain_clamp.sv
module gain_clamp #(
  parameter int IW = 19,
  parameter int OW = gain_pkg::SAMPLE_W
) (
  input  logic signed [IW-1:0] wide,
  output logic signed [OW-1:0] narrow
);
  localparam logic signed [IW-1:0] HI_W = {{(IW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [IW-1:0] LO_W = {{(IW-OW+1){1'b1}}, {(OW-1){1'b0}}};
  localparam logic signed [OW-1:0] HI_N = {1'b0, {(OW-1){1'b1}}};
  localparam logic signed [OW-1:0] LO_N = {1'b1, {(OW-1){1'b0}}};

  always_comb begin
    if (wide > HI_W)      narrow = HI_N;
    else if (wide < LO_W) narrow = LO_N;
    else                  narrow = wide[OW-1:0];
  end
endmodule

// File: rtl/gain_lane.sv
module gain_lane #(
  parameter int SW = gain_pkg::SAMPLE_W,
  parameter int CW = gain_pkg::COEF_W,
  parameter int FB = gain_pkg::FRAC_BITS,
  localparam int RW = SW + CW + 1 - FB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] out_data,
  input  logic [CW-1:0] gain,
  input  logic          mute
);
  localparam logic [CW-1:0] UNITY = CW'(1) << FB;

  logic signed [RW-1:0] scaled;
  logic signed [SW-1:0] clamped;
  logic                 accept;

  gain_product #(.SW(SW), .CW(CW), .FB(FB)) u_prod (
    .sample (in_data),
    .coef   (gain),
    .scaled (scaled)
  );

  gain_clamp #(.IW(RW), .OW(SW)) u_clamp (
    .wide   (scaled),
    .narrow (clamped)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= mute ? '0 : clamped;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_zero_gain_R1: assert property (@(posedge clk) disable iff (rst)
    accept && (gain == '0) |=> out_data == '0);

  assert_unity_R2: assert property (@(posedge clk) disable iff (rst)
    accept && !mute && (gain == UNITY) |=> out_data == $past(in_data));

  assert_mute_R5: assert property (@(posedge clk) disable iff (rst)
    accept && mute |=> out_data == '0);

  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/audio_gain_pair.sv
module audio_gain_pair
  import gain_pkg::*;
#(
  parameter int SW = SAMPLE_W,
  parameter int CW = COEF_W,
  parameter int FB = FRAC_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [SW-1:0] tx_in_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [SW-1:0] tx_out_data,
  input  logic [CW-1:0] tx_gain,
  input  logic          tx_mute,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [SW-1:0] rx_in_data,
  output logic          rx_out_valid,
  input  logic          rx_out_ready,
  output logic [SW-1:0] rx_out_data,
  input  logic [CW-1:0] rx_gain,
  input  logic          rx_mute
);
  logic [LANES-1:0] iv, ir, ov, orr, mu;
  logic [SW-1:0]    idat [LANES];
  logic [SW-1:0]    odat [LANES];
  logic [CW-1:0]    gn   [LANES];

  always_comb begin
    iv[LANE_TX]   = tx_in_valid;
    iv[LANE_RX]   = rx_in_valid;
    orr[LANE_TX]  = tx_out_ready;
    orr[LANE_RX]  = rx_out_ready;
    mu[LANE_TX]   = tx_mute;
    mu[LANE_RX]   = rx_mute;
    idat[LANE_TX] = tx_in_data;
    idat[LANE_RX] = rx_in_data;
    gn[LANE_TX]   = tx_gain;
    gn[LANE_RX]   = rx_gain;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    gain_lane #(.SW(SW), .CW(CW), .FB(FB)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (iv[l]),
      .in_ready  (ir[l]),
      .in_data   (idat[l]),
      .out_valid (ov[l]),
      .out_ready (orr[l]),
      .out_data  (odat[l]),
      .gain      (gn[l]),
      .mute      (mu[l])
    );
  end

  assign tx_in_ready  = ir[LANE_TX];
  assign rx_in_ready  = ir[LANE_RX];
  assign tx_out_valid = ov[LANE_TX];
  assign rx_out_valid = ov[LANE_RX];
  assign tx_out_data  = odat[LANE_TX];
  assign rx_out_data  = odat[LANE_RX];
endmodule

// File: tb/sim_audio_gain_pair.sv
module sim_audio_gain_pair;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] iv, ir, ov, ordy, im;
  logic [15:0] idat [2];
  logic [15:0] odat [2];
  logic [15:0] ig   [2];
  int checks = 0;
  int errors = 0;
  logic [15:0] q0 [$];
  logic [15:0] q1 [$];

  always #4 clk = ~clk;

  audio_gain_pair u0 (
    .clk(clk), .rst(rst),
    .tx_in_valid(iv[0]), .tx_in_ready(ir[0]), .tx_in_data(idat[0]),
    .tx_out_valid(ov[0]), .tx_out_ready(ordy[0]), .tx_out_data(odat[0]),
    .tx_gain(ig[0]), .tx_mute(im[0]),
    .rx_in_valid(iv[1]), .rx_in_ready(ir[1]), .rx_in_data(idat[1]),
    .rx_out_valid(ov[1]), .rx_out_ready(ordy[1]), .rx_out_data(odat[1]),
    .rx_gain(ig[1]), .rx_mute(im[1])
  );

  function automatic logic [15:0] model(logic [15:0] s, logic [15:0] g, logic m);
    longint p;
    if (m) return 16'h0000;
    p = longint'($signed(s)) * longint'(g);
    p = (p + 64'sd8192) >>> 14;
    if (p > 32767) return 16'h7FFF;
    if (p < -32768) return 16'h8000;
    return p[15:0];
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one sample on a lane, then check it one edge later
  task automatic send(int l, logic [15:0] s, logic [15:0] g, logic m, string req);
    @(negedge clk);
    iv[l] = 1'b1; idat[l] = s; ig[l] = g; im[l] = m; ordy[l] = 1'b1;
    @(negedge clk);
    iv[l] = 1'b0;
    chk({req, " valid"}, {15'd0, ov[l]}, 16'd1);
    chk(req, odat[l], model(s, g, m));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    iv = '0; ordy = '1; im = '0;
    for (int l = 0; l < 2; l++) begin idat[l] = '0; ig[l] = 16'h4000; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R7: reset state
    chk("R7 reset out_valid", {14'd0, ov}, 16'd0);
    chk("R7 reset in_ready", {14'd0, ir}, 16'd3);

    send(0, 16'h1234, 16'h0000, 1'b0, "R1 zero gain");
    send(1, 16'h8000, 16'h0000, 1'b0, "R1 zero gain rx");
    send(0, 16'h7FFF, 16'h4000, 1'b0, "R2 unity max");
    send(0, 16'h8000, 16'h4000, 1'b0, "R2 unity min");
    send(1, 16'hFFFF, 16'h4000, 1'b0, "R2 unity -1");
    send(0, 16'd1000, 16'h7FFF, 1'b0, "R3 near 2x");
    chk("R3 literal 2000", model(16'd1000, 16'h7FFF, 1'b0), 16'd2000);
    send(0, 16'd1, 16'h2000, 1'b0, "R3 round half up +");
    send(0, 16'hFFFF, 16'h2000, 1'b0, "R3 round half up -");
    send(1, 16'h7FFF, 16'h7FFF, 1'b0, "R4 saturate high");
    send(1, 16'h8000, 16'h7FFF, 1'b0, "R4 saturate low");
    send(0, 16'hC000, 16'hFFFF, 1'b0, "R4 saturate large coef");
    send(0, 16'h4321, 16'h7FFF, 1'b1, "R5 mute");

    // R6: lanes side by side with different settings
    @(negedge clk);
    iv = 2'b11; idat[0] = 16'd3000; idat[1] = 16'd3000;
    ig[0] = 16'h4000; ig[1] = 16'h2000; im = 2'b10; ordy = 2'b11;
    @(negedge clk);
    iv = '0;
    chk("R6 tx lane", odat[0], 16'd3000);
    chk("R6 rx lane muted", odat[1], 16'd0);
    im = '0;

    // R8/R9: back-pressure and coefficient capture on lane 0
    @(negedge clk);
    ordy[0] = 1'b0; iv[0] = 1'b1; idat[0] = 16'd100; ig[0] = 16'h4000;
    @(negedge clk);
    idat[0] = 16'd200; ig[0] = 16'h2000;
    #1;
    chk("R8 held valid", {15'd0, ov[0]}, 16'd1);
    chk("R8 in_ready low", {15'd0, ir[0]}, 16'd0);
    chk("R8 held data", odat[0], 16'd100);
    @(negedge clk);
    ig[0] = 16'h7FFF; im[0] = 1'b1;
    @(negedge clk);
    chk("R9 held after gain change", odat[0], 16'd100);
    im[0] = 1'b0;
    ordy[0] = 1'b1;
    #1;
    chk("R8 in_ready with drain", {15'd0, ir[0]}, 16'd1);
    @(negedge clk);
    iv[0] = 1'b0;
    chk("R9 gain at accept", odat[0], model(16'd200, 16'h7FFF, 1'b0));
    @(negedge clk);
    chk("R8 drained", {15'd0, ov[0]}, 16'd0);

    // random traffic with scoreboards on both lanes (R3 R6 R8)
    void'($urandom(32'd20240611));
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      for (int l = 0; l < 2; l++) begin
        iv[l] = 1'($urandom % 2);
        idat[l] = 16'($urandom);
        case ($urandom % 4)
          0: ig[l] = 16'h4000;
          1: ig[l] = 16'h7FFF;
          2: ig[l] = 16'h0000;
          default: ig[l] = 16'($urandom);
        endcase
        im[l] = (($urandom % 8) == 0);
        ordy[l] = (($urandom % 4) != 0);
      end
      #1;
      if (ov[0] && ordy[0]) chk("R3 random tx", odat[0], q0.pop_front());
      if (ov[1] && ordy[1]) chk("R6 random rx", odat[1], q1.pop_front());
      if (iv[0] && ir[0]) q0.push_back(model(idat[0], ig[0], im[0]));
      if (iv[1] && ir[1]) q1.push_back(model(idat[1], ig[1], im[1]));
    end
    @(negedge clk);
    iv = '0; ordy = '1;
    #1;
    if (ov[0]) chk("R8 drain tx", odat[0], q0.pop_front());
    if (ov[1]) chk("R8 drain rx", odat[1], q1.pop_front());
    @(negedge clk);
    chk("R8 queues empty", 16'(q0.size() + q1.size()), 16'd0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule